// File: doc/BRIEF.md
# Four-Channel DMA Controller

This block moves data between peripherals and memory on behalf of a host processor. The host programs each of the four channels with a 16-bit start address and a 16-bit count word, then writes a shared mode byte to enable channels and choose options. The 8-bit register path is reached through a select, a read strobe, a write strobe and a 4-bit offset. When an enabled channel raises its request, the controller asks the processor for the bus. Once the processor grants it, the controller acknowledges the winning channel. It then drives the memory address and the read and write strobe pair for that transfer, and advances the channel's address and count.

Each transfer takes an address phase followed by a strobe phase. A slow device can stretch the strobe phase by holding `ready_i` low. The controller flags the last transfer of a block and every 128th transfer. It can stop a finished channel on its own. It can also reload channel 2 from channel 3, so that blocks run back to back without the host stepping in.

Top module: `dma4_core`

## Requirements
- R1: After reset the mode byte is cleared, so no channel is enabled. Requests then raise no hold request and no acknowledge, all strobes stay low, and status reads 0x00.
- R2: Even offsets 0,2,4,6 address the start-address register of channels 0..3, and odd offsets 1,3,5,7 address their count word. Each access alternates low byte then high byte through one shared byte-order flag. A write of the mode byte at offset 8 clears that flag. Reads follow the same order.
- R3: A request from an enabled channel raises `hold_req_o` one clock later. No acknowledge appears until `hold_ack_i` is high. A request from a disabled channel is ignored. `hold_req_o` drops once no enabled request remains.
- R4: A transfer shows one address phase, in which the acknowledge is one-hot for the channel, `addr_o` holds the channel address and no strobe is active. This is followed by a strobe phase. After each transfer the channel address is one higher.
- R5: Count bits [15:14] select the cycle type. 01 asserts I/O read with memory write. 10 asserts memory read with I/O write. 00 (verify) asserts no strobe.
- R6: Mode bit 4 low selects fixed priority: the lowest-numbered requesting channel wins.
- R7: Mode bit 4 high selects rotating priority. The channel served last becomes lowest, so with all four requesting the grants run 0,1,2,3,0 after reset.
- R8: `tc_o` is high in the strobe phase of the transfer that starts with count bits [13:0] at zero. The channel's status bit (bits 3:0, one per channel) then stays set until status is read at offset 8.
- R9: With mode bit 6 set, a channel's enable is cleared after its terminal-count transfer, so a held request raises no further bus request.
- R10: `mark_o` is high in the strobe phase of a transfer whose remaining count has its low seven bits at zero. For a block length that is a multiple of 128, this is every 128th transfer.
- R11: With mode bit 7 set, a terminal-count transfer on channel 2 is followed by one update clock. In that clock status bit 4 is set and channel 3's address and count word are copied into channel 2. Channel 2 then stays enabled even with mode bit 6 set.
- R12: While `ready_i` is low in the strobe phase, that phase repeats with the same address and strobes. The transfer completes in the first clock with `ready_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access select |
| rd_i | input | 1 | Register read strobe, one clock |
| wr_i | input | 1 | Register write strobe, one clock |
| reg_addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| dreq_i | input | 4 | Per-channel transfer request |
| dack_o | output | 4 | Per-channel acknowledge, active high |
| hold_req_o | output | 1 | Bus request to the processor |
| hold_ack_i | input | 1 | Bus grant from the processor |
| ready_i | input | 1 | Strobe phase may end |
| bus_en_o | output | 1 | Controller owns the address bus |
| addr_o | output | 16 | Memory address of the transfer |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | Peripheral read strobe |
| io_wr_o | output | 1 | Peripheral write strobe |
| tc_o | output | 1 | Last transfer of the block |
| mark_o | output | 1 | 128th-transfer marker |

## Verification
The bench checks the exact transfer on which terminal count lands. A count that is off by one would flag the transfer before or after it, or would wrap silently. It runs a 256-transfer block to show that the marker fires on transfers 128 and 256 and on no others. It checks that a stopped channel never claims the bus again, and that a status read clears the sticky bit rather than leaving it set. It also checks that the update clock shows its flag, and that the chained block starts from channel 3's address with channel 3's cycle type. A wrong rotation pointer or a lost byte-order flag would show up as a wrong grant order or as bytes landing in the wrong half.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int NCH     = 4;
  localparam int CH_W    = $clog2(NCH);
  localparam int AW      = 16;
  localparam int CW      = 14;
  localparam int RW      = CW + 2;
  localparam int BYTE_W  = 8;
  localparam int RA_W    = 4;
  localparam int MARK_W  = 7;
  localparam int AUTO_DST = 2;
  localparam int AUTO_SRC = 3;
  localparam logic [RA_W-1:0] MODE_OFF = 4'h8;
  localparam int MB_ROT  = 4;
  localparam int MB_TCS  = 6;
  localparam int MB_AUTO = 7;

  typedef enum logic [1:0] {
    OP_VERIFY = 2'b00,
    OP_WRITE  = 2'b01,
    OP_READ   = 2'b10,
    OP_BAD    = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HREQ,
    ST_ADDR,
    ST_STRB,
    ST_UPD
  } seq_st_e;
endpackage

// File: rtl/dma4_regs.sv
module dma4_regs
  import dma4_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sel_i,
  input  logic                       wr_i,
  input  logic                       rd_i,
  input  logic [RA_W-1:0]            addr_i,
  input  logic [BYTE_W-1:0]          wdata_i,
  output logic [BYTE_W-1:0]          rdata_o,
  input  logic                       done_i,
  input  logic [CH_W-1:0]            done_ch_i,
  input  logic                       upd_i,
  output logic [NCH-1:0]             en_o,
  output logic                       rotate_o,
  output logic                       autoload_o,
  output logic [NCH-1:0][AW-1:0]     ch_addr_o,
  output logic [NCH-1:0][RW-1:0]     ch_cnt_o
);
  logic [NCH-1:0][AW-1:0] addr_q;
  logic [NCH-1:0][RW-1:0] cnt_q;
  logic [NCH-1:0]         en_q, tc_q;
  logic                   rot_q, tcs_q, auto_q, ff_q;
  logic                   host_wr, host_rd, is_ch, is_mode, done_tc, keep_en;
  logic [CH_W-1:0]        ch_sel;
  logic [AW-1:0]          rd16;

  assign host_wr = sel_i && wr_i;
  assign host_rd = sel_i && rd_i;
  assign is_ch   = !addr_i[RA_W-1];
  assign is_mode = (addr_i == MODE_OFF);
  assign ch_sel  = addr_i[CH_W:1];
  assign done_tc = (cnt_q[done_ch_i][CW-1:0] == '0);
  // autoload keeps the chained channel alive past its terminal count
  assign keep_en = auto_q && (done_ch_i == CH_W'(AUTO_DST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (host_wr && is_ch && ch_sel == CH_W'(c)) begin
          if (!addr_i[0]) begin
            if (ff_q) addr_q[c][AW-1:BYTE_W] <= wdata_i;
            else      addr_q[c][BYTE_W-1:0]  <= wdata_i;
          end else begin
            if (ff_q) cnt_q[c][RW-1:BYTE_W]  <= wdata_i;
            else      cnt_q[c][BYTE_W-1:0]   <= wdata_i;
          end
        end
        if (done_i && done_ch_i == CH_W'(c)) begin
          addr_q[c]         <= addr_q[c] + 1'b1;
          cnt_q[c][CW-1:0]  <= cnt_q[c][CW-1:0] - 1'b1;
        end
        if (upd_i && c == AUTO_DST) begin
          addr_q[c] <= addr_q[AUTO_SRC];
          cnt_q[c]  <= cnt_q[AUTO_SRC];
        end
      end
    end
  end

  // mode bit 5 is reserved and not stored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      rot_q  <= 1'b0;
      tcs_q  <= 1'b0;
      auto_q <= 1'b0;
    end else begin
      if (host_wr && is_mode) begin
        en_q   <= wdata_i[NCH-1:0];
        rot_q  <= wdata_i[MB_ROT];
        tcs_q  <= wdata_i[MB_TCS];
        auto_q <= wdata_i[MB_AUTO];
      end
      if (done_i && done_tc && tcs_q && !keep_en) en_q[done_ch_i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q <= '0;
      ff_q <= 1'b0;
    end else begin
      if (host_rd && is_mode) tc_q <= '0;
      if (done_i && done_tc) tc_q[done_ch_i] <= 1'b1;
      if (host_wr && is_mode) ff_q <= 1'b0;
      else if ((host_wr || host_rd) && is_ch) ff_q <= !ff_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    rd16    = addr_i[0] ? cnt_q[ch_sel] : addr_q[ch_sel];
    if (sel_i) begin
      if (is_mode) begin
        rdata_o[NCH-1:0] = tc_q;
        rdata_o[NCH]     = upd_i;
      end else if (is_ch) begin
        rdata_o = ff_q ? rd16[AW-1:BYTE_W] : rd16[BYTE_W-1:0];
      end
    end
  end

  assign en_o       = en_q;
  assign rotate_o   = rot_q;
  assign autoload_o = auto_q;
  assign ch_addr_o  = addr_q;
  assign ch_cnt_o   = cnt_q;

  assert_tc_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && done_tc && tcs_q && !keep_en && !(host_wr && is_mode))
      |=> !en_q[$past(done_ch_i)]);

  assert_tc_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_rd && is_mode) |=> ((tc_q & $past(tc_q)) == $past(tc_q)));

  assert_tc_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && done_tc) |=> tc_q[$past(done_ch_i)]);
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb
  import dma4_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   req_i,
  input  logic             rotate_i,
  input  logic             adv_i,
  input  logic [CH_W-1:0]  adv_ch_i,
  output logic [CH_W-1:0]  grant_o,
  output logic             valid_o
);
  logic [CH_W-1:0] last_q, idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= CH_W'(NCH - 1);
    else if (adv_i) last_q <= adv_ch_i;
  end

  always_comb begin
    grant_o = '0;
    idx     = '0;
    valid_o = |req_i;
    if (rotate_i) begin
      // scan from the channel after the last served; nearest hit wins
      for (int k = NCH; k >= 1; k--) begin
        idx = last_q + CH_W'(k);
        if (req_i[idx]) grant_o = idx;
      end
    end else begin
      for (int k = NCH - 1; k >= 0; k--) begin
        if (req_i[k]) grant_o = CH_W'(k);
      end
    end
  end

  assert_fixed_prio_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !rotate_i) |-> ((req_i & ((NCH'(1) << grant_o) - 1'b1)) == '0));

  assert_grant_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> req_i[grant_o]);
endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
  import dma4_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [CH_W-1:0]         grant_i,
  input  logic                    hold_ack_i,
  input  logic                    ready_i,
  input  logic                    autoload_i,
  input  logic [NCH-1:0][AW-1:0]  ch_addr_i,
  input  logic [NCH-1:0][RW-1:0]  ch_cnt_i,
  output logic                    hold_req_o,
  output logic                    bus_en_o,
  output logic [NCH-1:0]          dack_o,
  output logic [AW-1:0]           addr_o,
  output logic                    mem_rd_o,
  output logic                    mem_wr_o,
  output logic                    io_rd_o,
  output logic                    io_wr_o,
  output logic                    tc_o,
  output logic                    mark_o,
  output logic                    done_o,
  output logic [CH_W-1:0]         done_ch_o,
  output logic                    upd_o
);
  seq_st_e         st_q, st_d;
  logic [CH_W-1:0] ch_q;
  logic [RW-1:0]   cur_cnt;
  op_e             cur_op;
  logic            in_xfer, strb, last_xfer, chain;

  assign cur_cnt   = ch_cnt_i[ch_q];
  assign cur_op    = op_e'(cur_cnt[RW-1:CW]);
  assign last_xfer = (cur_cnt[CW-1:0] == '0);
  assign in_xfer   = (st_q == ST_ADDR) || (st_q == ST_STRB);
  assign strb      = (st_q == ST_STRB);
  assign chain     = last_xfer && autoload_i && (ch_q == CH_W'(AUTO_DST));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (valid_i) st_d = ST_HREQ;
      ST_HREQ: begin
        if (!valid_i)        st_d = ST_IDLE;
        else if (hold_ack_i) st_d = ST_ADDR;
      end
      ST_ADDR: st_d = ST_STRB;
      ST_STRB: if (ready_i) st_d = chain ? ST_UPD : ST_HREQ;
      ST_UPD:  st_d = ST_HREQ;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      ch_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_HREQ && hold_ack_i && valid_i) ch_q <= grant_i;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_dack
    assign dack_o[c] = in_xfer && (ch_q == CH_W'(c));
  end

  always_comb begin
    mem_rd_o = 1'b0;
    mem_wr_o = 1'b0;
    io_rd_o  = 1'b0;
    io_wr_o  = 1'b0;
    unique case (cur_op)
      OP_WRITE: begin io_rd_o  = strb; mem_wr_o = strb; end
      OP_READ:  begin mem_rd_o = strb; io_wr_o  = strb; end
      default: ;
    endcase
  end

  assign hold_req_o = (st_q != ST_IDLE);
  assign bus_en_o   = in_xfer;
  assign addr_o     = in_xfer ? ch_addr_i[ch_q] : '0;
  assign tc_o       = strb && last_xfer;
  assign mark_o     = strb && (cur_cnt[MARK_W-1:0] == '0);
  assign done_o     = strb && ready_i;
  assign done_ch_o  = ch_q;
  assign upd_o      = (st_q == ST_UPD);

  assert_dack_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dack_o));

  assert_ack_before_xfer_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ADDR) |-> $past(hold_ack_i));

  assert_strobe_pairs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o) && !(io_rd_o && io_wr_o) && !(mem_rd_o && io_rd_o));

  assert_ready_stretch_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_STRB && !ready_i) |=> (st_q == ST_STRB && $stable(addr_o)));

  assert_tc_in_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (|dack_o && hold_req_o));
endmodule

// File: rtl/dma4_core.sv
module dma4_core
  import dma4_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [RA_W-1:0]    reg_addr_i,
  input  logic [BYTE_W-1:0]  wdata_i,
  output logic [BYTE_W-1:0]  rdata_o,
  input  logic [NCH-1:0]     dreq_i,
  output logic [NCH-1:0]     dack_o,
  output logic               hold_req_o,
  input  logic               hold_ack_i,
  input  logic               ready_i,
  output logic               bus_en_o,
  output logic [AW-1:0]      addr_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic               io_rd_o,
  output logic               io_wr_o,
  output logic               tc_o,
  output logic               mark_o
);
  logic [NCH-1:0]         en, elig;
  logic                   rotate, autoload, done, upd, valid;
  logic [CH_W-1:0]        done_ch, grant;
  logic [NCH-1:0][AW-1:0] ch_addr;
  logic [NCH-1:0][RW-1:0] ch_cnt;

  assign elig = dreq_i & en;

  dma4_regs u_regs (
    .clk_i, .rst_ni, .sel_i, .wr_i, .rd_i,
    .addr_i     (reg_addr_i),
    .wdata_i,
    .rdata_o,
    .done_i     (done),
    .done_ch_i  (done_ch),
    .upd_i      (upd),
    .en_o       (en),
    .rotate_o   (rotate),
    .autoload_o (autoload),
    .ch_addr_o  (ch_addr),
    .ch_cnt_o   (ch_cnt)
  );

  dma4_arb u_arb (
    .clk_i, .rst_ni,
    .req_i    (elig),
    .rotate_i (rotate),
    .adv_i    (done),
    .adv_ch_i (done_ch),
    .grant_o  (grant),
    .valid_o  (valid)
  );

  dma4_seq u_seq (
    .clk_i, .rst_ni,
    .valid_i    (valid),
    .grant_i    (grant),
    .hold_ack_i,
    .ready_i,
    .autoload_i (autoload),
    .ch_addr_i  (ch_addr),
    .ch_cnt_i   (ch_cnt),
    .hold_req_o,
    .bus_en_o,
    .dack_o,
    .addr_o,
    .mem_rd_o, .mem_wr_o, .io_rd_o, .io_wr_o,
    .tc_o, .mark_o,
    .done_o     (done),
    .done_ch_o  (done_ch),
    .upd_o      (upd)
  );
endmodule

// File: tb/dma4_core_bench.sv
module dma4_core_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       sel_i = 0, rd_i = 0, wr_i = 0;
  logic [3:0] reg_addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic [3:0] dreq_i = '0, dack_o;
  logic       hold_req_o, hold_ack_i = 1'b0, ready_i = 1'b1, bus_en_o;
  logic [15:0] addr_o;
  logic       mem_rd_o, mem_wr_o, io_rd_o, io_wr_o, tc_o, mark_o;
  logic       auto_ack = 1'b0;
  int         checks = 0, fails = 0;

  dma4_core u_dma4_core (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(negedge clk_i) hold_ack_i <= auto_ack && hold_req_o;

  function automatic logic [3:0] strb_now();
    return {mem_rd_o, mem_wr_o, io_rd_o, io_wr_o};
  endfunction

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 0; dreq_i = '0; sel_i = 0; rd_i = 0; wr_i = 0;
    ready_i = 1; auto_ack = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    sel_i = 1; wr_i = 1; reg_addr_i = a; wdata_i = d;
    @(negedge clk_i);
    sel_i = 0; wr_i = 0;
  endtask

  task automatic host_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i);
    sel_i = 1; rd_i = 1; reg_addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    sel_i = 0; rd_i = 0;
  endtask

  task automatic load_ch(input int c, input logic [15:0] a, input logic [15:0] n);
    host_wr(4'(2*c), a[7:0]);     host_wr(4'(2*c), a[15:8]);
    host_wr(4'(2*c+1), n[7:0]);   host_wr(4'(2*c+1), n[15:8]);
  endtask

  // strobe vector order: {mem_rd, mem_wr, io_rd, io_wr}
  task automatic run_one(input int ch, input int exp_addr, input logic [3:0] exp_strb,
                         input bit exp_tc, input bit drop, input string req,
                         output bit mark_seen);
    int n = 0;
    do begin @(negedge clk_i); n++; end while (dack_o == '0 && n < 40);
    check_eq({req, " dack"}, int'(dack_o), 1 << ch);
    check_eq({req, " addr"}, int'(addr_o), exp_addr);
    check_eq({req, " addr-phase strobes"}, int'(strb_now()), 0);
    if (drop) dreq_i[ch] = 1'b0;
    @(negedge clk_i);
    check_eq({req, " strobes"}, int'(strb_now()), int'(exp_strb));
    check_eq({req, " tc"}, int'(tc_o), int'(exp_tc));
    mark_seen = mark_o;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    check_eq("R1 hold_req", hold_req_o, 0);
    check_eq("R1 dack", dack_o, 0);
    check_eq("R1 strobes", strb_now(), 0);
    host_rd(4'h8, d);
    check_eq("R1 status", d, 0);
    dreq_i = 4'hF;
    repeat (3) @(negedge clk_i);
    check_eq("R1 no hold with mode cleared", hold_req_o, 0);
    dreq_i = '0;
  endtask

  task automatic t_regs();
    logic [7:0] d;
    do_reset();
    host_wr(4'h2, 8'h56); host_wr(4'h2, 8'h34);
    host_rd(4'h2, d); check_eq("R2 low byte", d, 8'h56);
    host_rd(4'h2, d); check_eq("R2 high byte", d, 8'h34);
    host_wr(4'h2, 8'hAA);
    host_wr(4'h8, 8'h00);
    host_wr(4'h2, 8'h77);
    host_wr(4'h8, 8'h00);
    host_rd(4'h2, d); check_eq("R2 flag cleared by mode write", d, 8'h77);
    host_rd(4'h2, d); check_eq("R2 high kept", d, 8'h34);
  endtask

  task automatic t_handshake();
    bit m;
    do_reset();
    load_ch(0, 16'h0100, {2'b01, 14'd9});
    host_wr(4'h8, 8'h01);
    dreq_i = 4'b0010;
    repeat (3) @(negedge clk_i);
    check_eq("R3 disabled channel ignored", hold_req_o, 0);
    dreq_i = 4'b0001;
    @(negedge clk_i);
    check_eq("R3 hold request raised", hold_req_o, 1);
    @(negedge clk_i);
    check_eq("R3 no dack before grant", dack_o, 0);
    auto_ack = 1;
    run_one(0, 16'h0100, 4'b0110, 0, 1, "R4 R5 write cycle", m);
    repeat (3) @(negedge clk_i);
    check_eq("R3 hold released", hold_req_o, 0);
  endtask

  task automatic t_tc();
    bit m;
    logic [7:0] d;
    do_reset();
    load_ch(0, 16'h0200, {2'b01, 14'd2});
    host_wr(4'h8, 8'h01);
    auto_ack = 1; dreq_i = 4'b0001;
    run_one(0, 16'h0200, 4'b0110, 0, 0, "R8 xfer1", m);
    run_one(0, 16'h0201, 4'b0110, 0, 0, "R8 xfer2", m);
    run_one(0, 16'h0202, 4'b0110, 1, 1, "R8 last", m);
    repeat (3) @(negedge clk_i);
    host_rd(4'h8, d); check_eq("R8 status sticky", d, 8'h01);
    host_rd(4'h8, d); check_eq("R8 status cleared by read", d, 8'h00);
  endtask

  task automatic t_tcstop();
    bit m;
    do_reset();
    load_ch(1, 16'h0300, {2'b10, 14'd0});
    host_wr(4'h8, 8'h42);
    auto_ack = 1; dreq_i = 4'b0010;
    run_one(1, 16'h0300, 4'b1001, 1, 0, "R9 R5 read cycle", m);
    repeat (6) @(negedge clk_i);
    check_eq("R9 no request after stop", hold_req_o, 0);
    check_eq("R9 no dack after stop", dack_o, 0);
    dreq_i = '0;
  endtask

  task automatic t_fixed();
    bit m;
    do_reset();
    load_ch(0, 16'h0A00, {2'b00, 14'd100});
    load_ch(1, 16'h1100, {2'b00, 14'd100});
    load_ch(3, 16'h3300, {2'b00, 14'd100});
    host_wr(4'h8, 8'h0F);
    auto_ack = 1; dreq_i = 4'b1010;
    run_one(1, 16'h1100, 4'b0000, 0, 1, "R6 ch1 first", m);
    run_one(3, 16'h3300, 4'b0000, 0, 1, "R6 ch3 next", m);
    repeat (4) @(negedge clk_i);
    dreq_i = 4'b1001;
    run_one(0, 16'h0A00, 4'b0000, 0, 0, "R6 ch0 wins", m);
    run_one(0, 16'h0A01, 4'b0000, 0, 0, "R6 ch0 again", m);
    dreq_i = '0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_rotate();
    bit m;
    do_reset();
    for (int c = 0; c < 4; c++) load_ch(c, 16'(c << 12), {2'b00, 14'd50});
    host_wr(4'h8, 8'h1F);
    auto_ack = 1; dreq_i = 4'hF;
    for (int c = 0; c < 4; c++) run_one(c, c << 12, 4'b0000, 0, 0, "R7 rotation", m);
    run_one(0, 16'h0001, 4'b0000, 0, 1, "R7 wrap to ch0", m);
    dreq_i = '0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_mark();
    bit m;
    int marks = 0;
    do_reset();
    load_ch(1, 16'h4000, {2'b00, 14'd255});
    host_wr(4'h8, 8'h02);
    auto_ack = 1; dreq_i = 4'b0010;
    for (int i = 0; i < 256; i++) begin
      run_one(1, 16'h4000 + i, 4'b0000, i == 255, i == 255, "R10 block", m);
      if (m) marks++;
      check_eq("R10 mark position", m, ((i + 1) % 128) == 0);
    end
    check_eq("R10 mark total", marks, 2);
  endtask

  task automatic t_autoload();
    bit m;
    logic [7:0] d;
    do_reset();
    load_ch(2, 16'h5000, {2'b01, 14'd1});
    load_ch(3, 16'h6000, {2'b10, 14'd0});
    host_wr(4'h8, 8'hC4);
    auto_ack = 1; dreq_i = 4'b0100;
    run_one(2, 16'h5000, 4'b0110, 0, 0, "R11 first block", m);
    run_one(2, 16'h5001, 4'b0110, 1, 0, "R11 first block end", m);
    host_rd(4'h8, d); check_eq("R11 update flag", d, 8'h14);
    run_one(2, 16'h6000, 4'b1001, 1, 1, "R11 chained block", m);
    host_rd(4'h8, d); check_eq("R11 second update", d, 8'h14);
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_ready();
    logic [7:0] d;
    int n = 0;
    do_reset();
    load_ch(0, 16'h0010, {2'b10, 14'd5});
    host_wr(4'h8, 8'h01);
    ready_i = 0; auto_ack = 1; dreq_i = 4'b0001;
    do begin @(negedge clk_i); n++; end while (dack_o == '0 && n < 40);
    check_eq("R12 addr phase", addr_o, 16'h0010);
    dreq_i = '0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      check_eq("R12 strobes held", strb_now(), 4'b1001);
      check_eq("R12 dack held", dack_o, 4'b0001);
      check_eq("R12 addr held", addr_o, 16'h0010);
    end
    ready_i = 1;
    @(negedge clk_i);
    check_eq("R12 completes on ready", strb_now(), 0);
    host_rd(4'h0, d); check_eq("R4 address advanced", d, 8'h11);
    host_rd(4'h0, d); check_eq("R4 address high", d, 8'h00);
    host_rd(4'h1, d); check_eq("R12 count decremented", d, 8'h04);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_handshake();
    t_tc();
    t_tcstop();
    t_fixed();
    t_rotate();
    t_mark();
    t_autoload();
    t_ready();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule